// File: doc/BRIEF.md
# Thread Interrupt Priority Presenter

This block is the interrupt presentation context of one hardware thread. It keeps a bitmap of pending priorities for each of two rings, a current processor priority (the threshold the thread accepts), a pending priority register that reports the most favoured waiting priority, and a notification status byte. It drives one interrupt line to the processor. Priority 0 is the most favoured. The all-ones byte (0xFF) means "none".

The physical ring is always live. The pool ring can be pushed (restored) and pulled (saved away). Both rings share one threshold, one pending-priority register, one status byte and one line. Software acts on the block through priority requests, threshold writes, an acknowledge strobe and the pool push and pull commands. The outputs present the next interrupt to take. Every register output updates on the clock edge that follows the event that caused it. The acknowledge result is combinational in the strobe cycle.

Top module: `tip_presenter`

## Requirements
- R1: After reset, both pending bitmaps are 0, the pool ring is not live, the threshold and the pending priority are 0xFF, the status byte is 0 and the line is low.
- R2: A request with priority p below NPRIO (8) sets bit p of the physical bitmap when `req_pool`=0, and of the pool bitmap when `req_pool`=1. A request with p of NPRIO or more has no effect.
- R3: The pending priority equals the smaller of the threshold and the lowest set bit of the physical bitmap merged with the pool bitmap. The pool bitmap counts only while the pool ring is live. When no bit counts, the pending priority is 0xFF, so it never exceeds the threshold.
- R4: An interrupt is presented only when the lowest counted pending bit is strictly below the threshold. Presenting raises the line and sets status bit 7. Status bit 6 is set when the presented priority comes from the pool ring only; on a tie the physical ring is chosen. Otherwise the status byte is 0 and the line is low.
- R5: A threshold write takes effect on the next edge. A write of a value at or below the presented priority clears the status byte and drops the line. A write of a less favoured value leaves the presented interrupt unchanged.
- R6: During an acknowledge strobe, `ack_prio` shows the presented priority, or 0xFF when nothing is presented. After an acknowledge of a presented interrupt, the status byte is 0, the threshold equals that priority, and its bit is cleared in the ring named by status bit 6. An acknowledge with nothing presented changes nothing.
- R7: A pool push while the pool ring is not live ORs `push_ipb` into the pool bitmap and makes the ring live. The pending priority is then formed from the merged bitmap. A push while the pool ring is live has no effect.
- R8: A pool pull while the pool ring is live clears the pool bitmap and marks the ring not live. A pull while the ring is not live has no effect.
- R9: After a pull, the physical bitmap alone is scanned again. The line drops only if no physical bit is below the threshold, so a presented physical interrupt stays up and a waiting physical one is presented.
- R10: The commands have fixed precedence: acknowledge, then threshold write, then push, then pull. A request in the same cycle is merged after the winning command.
- R11: Requests to the pool ring while it is not live are kept in the pool bitmap but never presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Interrupt request strobe |
| req_pool | input | 1 | Request targets the pool ring (1) or the physical ring (0) |
| req_prio | input | 8 | Request priority |
| cppr_wr | input | 1 | Threshold write strobe |
| cppr_wdata | input | 8 | New threshold value |
| ack | input | 1 | Acknowledge strobe |
| ack_prio | output | 8 | Acknowledged priority, or 0xFF when nothing is presented |
| push | input | 1 | Pool context push strobe |
| push_ipb | input | 8 | Saved pool bitmap to merge on push |
| pull | input | 1 | Pool context pull strobe |
| phys_ipb | output | 8 | Physical ring pending bitmap |
| pool_ipb | output | 8 | Pool ring pending bitmap |
| pool_valid | output | 1 | Pool ring live |
| cppr | output | 8 | Current threshold |
| pipr | output | 8 | Pending priority |
| nsr | output | 8 | Status: bit 7 presented, bit 6 from pool ring |
| irq | output | 1 | Interrupt line to the processor |

## Verification
Some rules are checked on every cycle: the pending priority never exceeds the threshold, the line and status bit 7 agree with the priority comparison, an acknowledge leaves the line low with the threshold set, a precluding threshold write drops the line, and ignored pushes, pulls and requests leave the bitmaps untouched. Other behaviour can only be shown by the bench's scenarios. These cover how a saved bitmap merges with requests queued while the pool ring was off, which ring wins a tied priority, and how a physical interrupt comes back after the pool ring is pulled. They also cover the command precedence when strobes coincide, and long runs of mixed traffic. A behavioural model follows all of these cycle by cycle.

// File: rtl/tip_pkg.sv
`timescale 1ns/1ps
package tip_pkg;
  localparam int PRIO_W = 8;
  localparam logic [PRIO_W-1:0] PRIO_NONE = '1;
  localparam int NSR_W = 8;
  localparam int NSR_PRES = 7;
  localparam int NSR_POOL = 6;
  localparam int NRING = 2;
  localparam int RING_PHYS = 0;
  localparam int RING_POOL = 1;

  // Less favoured of two is the larger number; keep the more favoured one.
  function automatic logic [PRIO_W-1:0] prio_min(input logic [PRIO_W-1:0] a,
                                                 input logic [PRIO_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [NSR_W-1:0] nsr_code(input logic pres, input logic from_pool);
    logic [NSR_W-1:0] v;
    v = '0;
    v[NSR_PRES] = pres;
    v[NSR_POOL] = pres & from_pool;
    return v;
  endfunction
endpackage

// File: rtl/tip_prio_scan.sv
`timescale 1ns/1ps
module tip_prio_scan
  import tip_pkg::*;
#(
  parameter int NPRIO = 8
) (
  input  logic [NPRIO-1:0]  bits,
  output logic              found,
  output logic [PRIO_W-1:0] prio
);
  logic [PRIO_W-1:0] chain [NPRIO+1];

  assign chain[NPRIO] = PRIO_NONE;
  for (genvar g = 0; g < NPRIO; g++) begin : g_chain
    assign chain[g] = bits[g] ? PRIO_W'(g) : chain[g+1];
  end

  assign found = |bits;
  assign prio  = chain[0];
endmodule

// File: rtl/tip_ipb_ring.sv
`timescale 1ns/1ps
module tip_ipb_ring #(
  parameter int NPRIO = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_all,
  input  logic [NPRIO-1:0] load_mask,
  input  logic [NPRIO-1:0] clr_mask,
  input  logic [NPRIO-1:0] set_mask,
  output logic [NPRIO-1:0] ipb_q,
  output logic [NPRIO-1:0] ipb_nxt
);
  logic [NPRIO-1:0] base;

  always_comb begin
    base    = clear_all ? '0 : ipb_q;
    ipb_nxt = ((base & ~clr_mask) | load_mask) | set_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ipb_q <= '0;
    else        ipb_q <= ipb_nxt;
  end
endmodule

// File: rtl/tip_signal.sv
`timescale 1ns/1ps
module tip_signal
  import tip_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cppr_load,
  input  logic [PRIO_W-1:0] cppr_val,
  input  logic              take,
  input  logic              phys_found,
  input  logic [PRIO_W-1:0] phys_prio,
  input  logic              pool_found,
  input  logic [PRIO_W-1:0] pool_prio,
  output logic [PRIO_W-1:0] cppr_q,
  output logic [PRIO_W-1:0] pipr_q,
  output logic [NSR_W-1:0]  nsr_q,
  output logic              present_nxt,
  output logic              src_pool_nxt
);
  logic [PRIO_W-1:0] cppr_nxt;
  logic [PRIO_W-1:0] best;
  logic [PRIO_W-1:0] pipr_nxt;
  logic [NSR_W-1:0]  nsr_nxt;

  always_comb begin
    if (cppr_load)  cppr_nxt = cppr_val;
    else if (take)  cppr_nxt = pipr_q;
    else            cppr_nxt = cppr_q;

    if (phys_found && (!pool_found || phys_prio <= pool_prio)) begin
      best = phys_prio;  src_pool_nxt = 1'b0;
    end else if (pool_found) begin
      best = pool_prio;  src_pool_nxt = 1'b1;
    end else begin
      best = PRIO_NONE;  src_pool_nxt = 1'b0;
    end

    present_nxt = best < cppr_nxt;
    pipr_nxt    = prio_min(best, cppr_nxt);
    nsr_nxt     = nsr_code(present_nxt, src_pool_nxt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cppr_q <= PRIO_NONE;
      pipr_q <= PRIO_NONE;
      nsr_q  <= '0;
    end else begin
      cppr_q <= cppr_nxt;
      pipr_q <= pipr_nxt;
      nsr_q  <= nsr_nxt;
    end
  end
endmodule

// File: rtl/tip_presenter.sv
`timescale 1ns/1ps
module tip_presenter
  import tip_pkg::*;
#(
  parameter int NPRIO = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_pool,
  input  logic [PRIO_W-1:0] req_prio,
  input  logic              cppr_wr,
  input  logic [PRIO_W-1:0] cppr_wdata,
  input  logic              ack,
  output logic [PRIO_W-1:0] ack_prio,
  input  logic              push,
  input  logic [NPRIO-1:0]  push_ipb,
  input  logic              pull,
  output logic [NPRIO-1:0]  phys_ipb,
  output logic [NPRIO-1:0]  pool_ipb,
  output logic              pool_valid,
  output logic [PRIO_W-1:0] cppr,
  output logic [PRIO_W-1:0] pipr,
  output logic [NSR_W-1:0]  nsr,
  output logic              irq
);
  localparam logic [NPRIO-1:0] ONE = {{(NPRIO-1){1'b0}}, 1'b1};

  // Named internal events
  logic presented, take, do_cppr, do_push, do_pull, req_ok;
  logic pool_valid_q, pool_valid_nxt;
  logic present_nxt, src_pool_nxt;
  logic [NPRIO-1:0] req_mask, ack_mask;
  logic [NRING-1:0] ring_live, found;
  logic [NPRIO-1:0] set_m [NRING];
  logic [NPRIO-1:0] clr_m [NRING];
  logic [NPRIO-1:0] load_m [NRING];
  logic [NPRIO-1:0] ipb_q [NRING];
  logic [NPRIO-1:0] ipb_nxt [NRING];
  logic [NPRIO-1:0] vis [NRING];
  logic [PRIO_W-1:0] scan_prio [NRING];
  logic [NRING-1:0] wipe;
  logic [PRIO_W-1:0] cppr_q, pipr_q;
  logic [NSR_W-1:0]  nsr_q;

  assign presented = nsr_q[NSR_PRES];
  assign take      = ack & presented;
  assign do_cppr   = cppr_wr & ~ack;
  assign do_push   = push & ~ack & ~cppr_wr & ~pool_valid_q;
  assign do_pull   = pull & ~ack & ~cppr_wr & ~push & pool_valid_q;
  assign req_ok    = req_valid & (req_prio < PRIO_W'(NPRIO));
  assign req_mask  = req_ok ? (ONE << req_prio) : '0;
  assign ack_mask  = take ? (ONE << pipr_q) : '0;

  always_comb begin
    if (do_push)      pool_valid_nxt = 1'b1;
    else if (do_pull) pool_valid_nxt = 1'b0;
    else              pool_valid_nxt = pool_valid_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pool_valid_q <= 1'b0;
    else        pool_valid_q <= pool_valid_nxt;
  end

  assign ring_live[RING_PHYS] = 1'b1;
  assign ring_live[RING_POOL] = pool_valid_nxt;

  for (genvar r = 0; r < NRING; r++) begin : g_ring
    localparam bit IS_POOL = (r == RING_POOL);
    assign set_m[r]  = (req_pool == IS_POOL) ? req_mask : '0;
    assign clr_m[r]  = (nsr_q[NSR_POOL] == IS_POOL) ? ack_mask : '0;
    assign load_m[r] = (IS_POOL && do_push) ? push_ipb : '0;
    assign wipe[r]   = IS_POOL && do_pull;

    tip_ipb_ring #(.NPRIO(NPRIO)) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_all (wipe[r]),
      .load_mask (load_m[r]),
      .clr_mask  (clr_m[r]),
      .set_mask  (set_m[r]),
      .ipb_q     (ipb_q[r]),
      .ipb_nxt   (ipb_nxt[r])
    );

    assign vis[r] = ipb_nxt[r] & {NPRIO{ring_live[r]}};

    tip_prio_scan #(.NPRIO(NPRIO)) u_scan (
      .bits  (vis[r]),
      .found (found[r]),
      .prio  (scan_prio[r])
    );
  end

  tip_signal u_sig (
    .clk          (clk),
    .rst_n        (rst_n),
    .cppr_load    (do_cppr),
    .cppr_val     (cppr_wdata),
    .take         (take),
    .phys_found   (found[RING_PHYS]),
    .phys_prio    (scan_prio[RING_PHYS]),
    .pool_found   (found[RING_POOL]),
    .pool_prio    (scan_prio[RING_POOL]),
    .cppr_q       (cppr_q),
    .pipr_q       (pipr_q),
    .nsr_q        (nsr_q),
    .present_nxt  (present_nxt),
    .src_pool_nxt (src_pool_nxt)
  );

  assign ack_prio   = presented ? pipr_q : PRIO_NONE;
  assign phys_ipb   = ipb_q[RING_PHYS];
  assign pool_ipb   = ipb_q[RING_POOL];
  assign pool_valid = pool_valid_q;
  assign cppr       = cppr_q;
  assign pipr       = pipr_q;
  assign nsr        = nsr_q;
  assign irq        = nsr_q[NSR_PRES];
endmodule

// File: rtl/tip_presenter_chk.sv
`timescale 1ns/1ps
module tip_presenter_chk
  import tip_pkg::*;
#(
  parameter int NPRIO = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_pool,
  input logic [PRIO_W-1:0] req_prio,
  input logic              cppr_wr,
  input logic [PRIO_W-1:0] cppr_wdata,
  input logic              ack,
  input logic              push,
  input logic [NPRIO-1:0]  push_ipb,
  input logic              pull,
  input logic [NPRIO-1:0]  phys_ipb,
  input logic [NPRIO-1:0]  pool_ipb,
  input logic              pool_valid,
  input logic [PRIO_W-1:0] cppr,
  input logic [PRIO_W-1:0] pipr,
  input logic [NSR_W-1:0]  nsr,
  input logic              irq,
  input logic              take
);
  assert_pipr_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pipr <= cppr);

  assert_line_favoured_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pipr < cppr) && nsr[NSR_PRES]);

  assert_quiet_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> (nsr == '0));

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !req_valid) |=> (!irq && cppr == $past(pipr)));

  assert_ack_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq && !req_valid) |=> ($stable(cppr) && $stable(phys_ipb) && $stable(pool_ipb)));

  assert_preclude_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cppr_wr && !ack && !req_valid && cppr_wdata <= pipr) |=> !irq);

  assert_push_merge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pool_valid && !ack && !cppr_wr && !req_valid)
      |=> (pool_valid && pool_ipb == ($past(pool_ipb) | $past(push_ipb))));

  assert_push_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pool_valid && !ack && !cppr_wr && !req_valid) |=> $stable(pool_ipb));

  assert_pull_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pull && pool_valid && !ack && !cppr_wr && !push && !(req_valid && req_pool))
      |=> (!pool_valid && pool_ipb == '0));

  assert_pull_keeps_phys_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pull && pool_valid && !ack && !cppr_wr && !push && irq && !nsr[NSR_POOL]) |=> irq);

  assert_bad_prio_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_prio >= PRIO_W'(NPRIO) && !ack && !cppr_wr && !push && !pull)
      |=> ($stable(phys_ipb) && $stable(pool_ipb)));
endmodule

bind tip_presenter tip_presenter_chk #(.NPRIO(NPRIO)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_pool   (req_pool),
  .req_prio   (req_prio),
  .cppr_wr    (cppr_wr),
  .cppr_wdata (cppr_wdata),
  .ack        (ack),
  .push       (push),
  .push_ipb   (push_ipb),
  .pull       (pull),
  .phys_ipb   (phys_ipb),
  .pool_ipb   (pool_ipb),
  .pool_valid (pool_valid),
  .cppr       (cppr),
  .pipr       (pipr),
  .nsr        (nsr),
  .irq        (irq),
  .take       (take)
);

// File: tb/sim_tip_presenter.sv
`timescale 1ns/1ps
module sim_tip_presenter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_pool = 0, cppr_wr = 0, ack = 0, push = 0, pull = 0;
  logic [7:0] req_prio = 0, cppr_wdata = 0, push_ipb = 0;
  logic [7:0] ack_prio, phys_ipb, pool_ipb, cppr, pipr, nsr;
  logic pool_valid, irq;

  always #4 clk = ~clk;

  tip_presenter u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pool(req_pool),
    .req_prio(req_prio), .cppr_wr(cppr_wr), .cppr_wdata(cppr_wdata), .ack(ack),
    .ack_prio(ack_prio), .push(push), .push_ipb(push_ipb), .pull(pull),
    .phys_ipb(phys_ipb), .pool_ipb(pool_ipb), .pool_valid(pool_valid),
    .cppr(cppr), .pipr(pipr), .nsr(nsr), .irq(irq)
  );

  int n_checks = 0;
  int n_err = 0;
  string tag = "R1";

  // Behavioural reference state
  bit [7:0] m_phys, m_pool, m_nsr;
  bit m_pv;
  int m_cppr, m_pipr;

  task automatic check(input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int first_set(input bit [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 255;
  endfunction

  task automatic model_reset();
    m_phys = 0; m_pool = 0; m_nsr = 0; m_pv = 0; m_cppr = 255; m_pipr = 255;
  endtask

  task automatic model_step();
    bit pres, took, wr, pu, pl;
    int ph, po, best;
    pres = m_nsr[7];
    took = ack && pres;
    wr = cppr_wr && !ack;
    pu = push && !ack && !cppr_wr && !m_pv;
    pl = pull && !ack && !cppr_wr && !push && m_pv;
    if (took) begin
      if (m_nsr[6]) m_pool[m_pipr] = 1'b0; else m_phys[m_pipr] = 1'b0;
      m_cppr = m_pipr;
    end
    if (wr) m_cppr = int'(cppr_wdata);
    if (pu) begin m_pool = m_pool | push_ipb; m_pv = 1; end
    if (pl) begin m_pool = 0; m_pv = 0; end
    if (req_valid && req_prio < 8) begin
      if (req_pool) m_pool[req_prio[2:0]] = 1'b1; else m_phys[req_prio[2:0]] = 1'b1;
    end
    ph = first_set(m_phys);
    po = m_pv ? first_set(m_pool) : 255;
    best = (po < ph) ? po : ph;
    if (best < m_cppr) begin
      m_nsr = (po < ph) ? 8'hC0 : 8'h80;
      m_pipr = best;
    end else begin
      m_nsr = 0;
      m_pipr = m_cppr;
    end
  endtask

  task automatic compare_all();
    check("cppr", int'(cppr), m_cppr);
    check("pipr", int'(pipr), m_pipr);
    check("nsr", int'(nsr), int'(m_nsr));
    check("irq", int'(irq), int'(m_nsr[7]));
    check("phys_ipb", int'(phys_ipb), int'(m_phys));
    check("pool_ipb", int'(pool_ipb), int'(m_pool));
    check("pool_valid", int'(pool_valid), int'(m_pv));
  endtask

  // One clock with the inputs currently driven, then return inputs to idle.
  task automatic cyc();
    #1;
    check("ack_prio", int'(ack_prio), m_nsr[7] ? m_pipr : 255);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    req_valid = 0; req_pool = 0; req_prio = 0; cppr_wr = 0; cppr_wdata = 0;
    ack = 0; push = 0; push_ipb = 0; pull = 0;
  endtask

  task automatic rq(input bit pool, input int p);
    req_valid = 1; req_pool = pool; req_prio = 8'(p); cyc();
  endtask
  task automatic wcppr(input int v);
    cppr_wr = 1; cppr_wdata = 8'(v); cyc();
  endtask
  task automatic do_ack(); ack = 1; cyc(); endtask
  task automatic do_push(input bit [7:0] v); push = 1; push_ipb = v; cyc(); endtask
  task automatic do_pull(); pull = 1; cyc(); endtask

  initial begin
    #1200000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    bit [31:0] lfsr;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tag = "R1";
    compare_all();
    check("reset irq", int'(irq), 0);
    check("reset cppr", int'(cppr), 255);

    tag = "R2_R4";  rq(0, 5);
    check("presented prio", int'(pipr), 5);
    check("status", int'(nsr), 8'h80);
    tag = "R3";     rq(0, 2);
    check("preempt prio", int'(pipr), 2);
    tag = "R6";
    ack = 1; #1; check("ack value", int'(ack_prio), 2); cyc();
    check("cppr after ack", int'(cppr), 2);
    check("line after ack", int'(irq), 0);
    check("bit cleared", int'(phys_ipb), 8'h20);
    tag = "R6_idle"; do_ack();
    check("idle ack cppr", int'(cppr), 2);
    tag = "R5";     wcppr(255);
    check("reopen", int'(pipr), 5);
    wcppr(6);
    check("lowering keeps", int'(irq), 1);
    wcppr(3);
    check("preclude line", int'(irq), 0);
    check("preclude pipr", int'(pipr), 3);
    tag = "R2_bad"; rq(0, 9); rq(1, 200);
    check("bad prio ignored", int'(phys_ipb), 8'h20);
    wcppr(255);
    tag = "R11";    rq(1, 1);
    check("pool off not shown", int'(pipr), 5);
    check("pool kept", int'(pool_ipb), 8'h02);
    tag = "R7";     do_push(8'h08);
    check("merged pool", int'(pool_ipb), 8'h0A);
    check("pool presents", int'(nsr), 8'hC0);
    check("merged pipr", int'(pipr), 1);
    do_push(8'h01);
    check("push ignored", int'(pool_ipb), 8'h0A);
    tag = "R9";     do_pull();
    check("pull cleared", int'(pool_ipb), 0);
    check("phys back", int'(pipr), 5);
    check("line kept", int'(irq), 1);
    tag = "R8";     do_pull();
    check("pull ignored", int'(pool_valid), 0);
    tag = "R4_tie"; do_ack(); wcppr(255);
    rq(0, 4); do_push(8'h10);
    check("tie phys", int'(nsr), 8'h80);
    do_ack();
    check("tie pool kept", int'(pool_ipb), 8'h10);
    check("tie phys cleared", int'(phys_ipb), 8'h00);
    tag = "R9_drop"; wcppr(255); do_pull();
    check("no phys, line low", int'(irq), 0);
    tag = "R10";
    rq(0, 3);
    ack = 1; cppr_wr = 1; cppr_wdata = 0; cyc();
    check("ack wins", int'(cppr), 3);
    cppr_wr = 1; cppr_wdata = 255; push = 1; push_ipb = 8'h01; cyc();
    check("write beats push", int'(pool_valid), 0);
    push = 1; push_ipb = 8'h40; pull = 1; cyc();
    check("push beats pull", int'(pool_valid), 1);

    tag = "R3_mix";
    lfsr = 32'h1ACE_B00C;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      req_valid  = lfsr[2] | lfsr[3];
      req_pool   = lfsr[4];
      req_prio   = {4'd0, lfsr[8:5]} % 8'd10;
      cppr_wr    = (lfsr[11:9] == 3'd0);
      cppr_wdata = lfsr[12] ? 8'hFF : {4'd0, lfsr[16:13]} % 8'd9;
      ack        = (lfsr[19:17] == 3'd1);
      push       = (lfsr[22:20] == 3'd2);
      push_ipb   = lfsr[30:23];
      pull       = (lfsr[27:25] == 3'd3);
      cyc();
    end

    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule